// File: doc/BRIEF.md
# SPI Flash Command Engine

This block runs a single SPI flash transaction on behalf of software through a small byte-wide register window. A transaction has three parts in order: an opcode byte, then up to eight payload bytes, then a programmable number of receive bytes. Software sets the opcode and a packed count register, then resets the FIFO pointer. It pushes the payload through one auto-incrementing data port and sets a go bit. It then polls until the engine reports idle.

One eight-entry FIFO serves both directions. Before the run it holds the payload. After the run the payload is still in the leading entries, and the received bytes sit in the entries that follow. To reach the received data, software rewinds the pointer and reads past the payload. The serial side is an SPI mode-0 master. The serial clock is the system clock divided by four. Bytes are shifted most significant bit first, and the chip select stays low for the whole transaction.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset the chip select is high, the serial clock is low, the control and status registers read 0x00 and the pointer register reads 0.
- R2: The byte written at offset 0x0 reads back unchanged. It is always the first byte shifted out, and it never occupies a FIFO entry.
- R3: Offset 0x1 reads back as written. Bits 3:0 are the payload count and bits 7:4 the receive count. A payload count above 8 is treated as 8.
- R4: When the payload count is 0, the engine receives one byte fewer than the receive field states, and a field of 0 then means no receive bytes.
- R5: A write or read at offset 0xC accesses the FIFO entry at the pointer and then advances the pointer modulo 8. Bits 2:0 of offset 0xD show the pointer.
- R6: Writing offset 0x2 with bit 4 set clears the pointer by the next cycle, including while a transaction runs. A single write with bits 4 and 0 both set clears the pointer and starts a transaction.
- R7: Writing offset 0x2 with bit 0 set starts a transaction when the engine is idle. Bit 0 of offset 0x2 and bit 7 of offset 0x3 read 1 while it runs and 0 afterwards.
- R8: After a transaction, FIFO entries 0 to n-1 still hold the n payload bytes, and the received bytes follow in entries n onward, in arrival order.
- R9: The serial clock is low when idle and rises once every 4 system clocks. MOSI is stable while the serial clock is high, and MISO is sampled on the rising edge. MOSI carries 0x00 during receive bytes.
- R10: Chip select is low from the first opcode bit through the last receive bit. Exactly 8 x (1 + payload + receive) clock pulses occur, all with chip select low.
- R11: While a transaction runs, a write to offset 0xC changes neither the FIFO nor the pointer, and a further go bit does nothing.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 4 | Register offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the addressed register |
| spi_sclk | output | 1 | Serial clock, mode 0 |
| spi_cs_n | output | 1 | Active-low chip select |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |

## Verification
A pointer clear and a transaction start can land in the same cycle, because both are carried by one write to the control register. The bench provokes this by leaving the pointer at 2 and then writing 0x11. It judges the result by reading the pointer as 0 while the status still shows busy, and by the scoreboard seeing exactly one opcode-payload-receive byte sequence. A second case writes a data-port byte and a repeated go bit during a transaction. It expects the pointer to stay unchanged, no extra serial bytes to appear, and the payload to read back intact.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam logic [3:0] OFS_OPCODE = 4'h0;
    localparam logic [3:0] OFS_COUNT  = 4'h1;
    localparam logic [3:0] OFS_CTRL   = 4'h2;
    localparam logic [3:0] OFS_STATUS = 4'h3;
    localparam logic [3:0] OFS_DATA   = 4'hC;
    localparam logic [3:0] OFS_PTR    = 4'hD;

    localparam int CTRL_GO_BIT   = 0;
    localparam int CTRL_PCLR_BIT = 4;
    localparam int STAT_BUSY_BIT = 7;

    typedef struct packed {
        logic [3:0] rx_n;
        logic [3:0] tx_n;
    } count_reg_t;

    typedef enum logic {
        SEQ_IDLE = 1'b0,
        SEQ_RUN  = 1'b1
    } seq_state_e;

    function automatic logic [4:0] payload_len(input logic [3:0] field,
                                               input logic [4:0] limit);
        logic [4:0] f5;
        f5 = {1'b0, field};
        return (f5 > limit) ? limit : f5;
    endfunction

    function automatic logic [4:0] receive_len(input logic [4:0] tx_eff,
                                               input logic [3:0] field);
        if (tx_eff != 5'd0)
            return {1'b0, field};
        else if (field == 4'd0)
            return 5'd0;
        else
            return {1'b0, field - 4'd1};
    endfunction

endpackage

// File: rtl/spi_cmd_fifo.sv
module spi_cmd_fifo #(
    parameter int DEPTH = 8,
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_we,
    input  logic             bus_adv,
    input  logic             ptr_clr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    output logic [PTR_W-1:0] ptr,
    input  logic             eng_we,
    input  logic [PTR_W-1:0] eng_waddr,
    input  logic [7:0]       eng_wdata,
    input  logic [PTR_W-1:0] eng_raddr,
    output logic [7:0]       eng_rdata
);

    logic [7:0] mem [DEPTH];

    assign bus_rdata = mem[ptr];
    assign eng_rdata = mem[eng_raddr];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= 8'h00;
        end else if (eng_we) begin
            mem[eng_waddr] <= eng_wdata;
        end else if (bus_we) begin
            mem[ptr] <= bus_wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || ptr_clr)
            ptr <= '0;
        else if (bus_we || bus_adv)
            ptr <= ptr + 1'b1;
    end

    assert_ptr_clear_R6: assert property (@(posedge clk) disable iff (rst)
        ptr_clr |=> (ptr == '0));

endmodule

// File: rtl/spi_cmd_shift.sv
module spi_cmd_shift (
    input  logic       clk,
    input  logic       rst,
    input  logic       load,
    input  logic [7:0] load_byte,
    input  logic       miso,
    output logic       byte_done,
    output logic [7:0] rx_byte,
    output logic       sclk,
    output logic       mosi
);

    localparam int PH_W  = 2;
    localparam int BIT_W = 3;

    logic [7:0]       tx_sh;
    logic [7:0]       rx_sh;
    logic [PH_W-1:0]  phase;
    logic [BIT_W-1:0] bit_idx;
    logic             run;
    logic             sample_ph;
    logic             last_ph;

    assign sample_ph = (phase == PH_W'(1));
    assign last_ph   = (phase == PH_W'(3));
    assign byte_done = run && last_ph && (bit_idx == BIT_W'(7));
    assign rx_byte   = rx_sh;
    assign sclk      = run & phase[PH_W-1];
    assign mosi      = run & tx_sh[7];

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_sh   <= 8'h00;
            rx_sh   <= 8'h00;
            phase   <= '0;
            bit_idx <= '0;
            run     <= 1'b0;
        end else if (load) begin
            tx_sh   <= load_byte;
            phase   <= '0;
            bit_idx <= '0;
            run     <= 1'b1;
        end else if (run) begin
            phase <= phase + 1'b1;
            if (sample_ph)
                rx_sh <= {rx_sh[6:0], miso};
            if (last_ph) begin
                tx_sh   <= {tx_sh[6:0], 1'b0};
                bit_idx <= bit_idx + 1'b1;
                if (bit_idx == BIT_W'(7))
                    run <= 1'b0;
            end
        end
    end

    assert_mosi_steady_R9: assert property (@(posedge clk) disable iff (rst)
        sclk |-> $stable(mosi));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MAX_TX = 8,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int IDX_W = $clog2(MAX_TX + 17)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [7:0]       opcode,
    input  count_reg_t       counts,
    input  logic             byte_done,
    input  logic [7:0]       rx_byte,
    input  logic [7:0]       fifo_rdata,
    output logic [PTR_W-1:0] fifo_raddr,
    output logic             fifo_we,
    output logic [PTR_W-1:0] fifo_waddr,
    output logic [7:0]       fifo_wdata,
    output logic             load,
    output logic [7:0]       load_byte,
    output logic             busy
);

    seq_state_e       state;
    logic [IDX_W-1:0] idx;
    logic [IDX_W-1:0] tx_l;
    logic [IDX_W-1:0] last_l;
    logic [4:0]       tx_eff;
    logic [4:0]       rx_eff;
    logic [IDX_W-1:0] next_idx;
    logic             more;

    assign tx_eff   = payload_len(counts.tx_n, 5'(MAX_TX));
    assign rx_eff   = receive_len(tx_eff, counts.rx_n);
    assign next_idx = idx + 1'b1;
    assign more     = (idx != last_l);
    assign busy     = (state == SEQ_RUN);

    always_comb begin
        load       = 1'b0;
        load_byte  = opcode;
        fifo_raddr = idx[PTR_W-1:0];
        fifo_waddr = PTR_W'(idx[PTR_W-1:0] - 1'b1);
        fifo_wdata = rx_byte;
        fifo_we    = 1'b0;
        if (state == SEQ_IDLE) begin
            load = go;
        end else if (byte_done) begin
            fifo_we = (idx > tx_l);
            if (more) begin
                load      = 1'b1;
                load_byte = (next_idx <= tx_l) ? fifo_rdata : 8'h00;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= SEQ_IDLE;
            idx    <= '0;
            tx_l   <= '0;
            last_l <= '0;
        end else if (state == SEQ_IDLE) begin
            if (go) begin
                state  <= SEQ_RUN;
                idx    <= '0;
                tx_l   <= IDX_W'(tx_eff);
                last_l <= IDX_W'(tx_eff) + IDX_W'(rx_eff);
            end
        end else if (byte_done) begin
            if (more)
                idx <= next_idx;
            else
                state <= SEQ_IDLE;
        end
    end

    assert_start_needs_go_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(go));

    assert_index_bound_R10: assert property (@(posedge clk) disable iff (rst)
        busy |-> (idx <= last_l));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int MAX_TX = 8
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] bus_addr,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [7:0] bus_wdata,
    output logic [7:0] bus_rdata,
    output logic       spi_sclk,
    output logic       spi_cs_n,
    output logic       spi_mosi,
    input  logic       spi_miso
);

    localparam int PTR_W = $clog2(DEPTH);

    logic [7:0]       opcode_q;
    count_reg_t       count_q;
    logic             busy;
    logic             go;
    logic             ptr_clr;
    logic             data_we;
    logic             data_adv;
    logic [7:0]       fifo_bus_rdata;
    logic [PTR_W-1:0] ptr;
    logic             eng_we;
    logic [PTR_W-1:0] eng_waddr;
    logic [7:0]       eng_wdata;
    logic [PTR_W-1:0] eng_raddr;
    logic [7:0]       eng_rdata;
    logic             load;
    logic [7:0]       load_byte;
    logic             byte_done;
    logic [7:0]       rx_byte;

    assign go       = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_GO_BIT];
    assign ptr_clr  = bus_wr && (bus_addr == OFS_CTRL) && bus_wdata[CTRL_PCLR_BIT];
    assign data_we  = bus_wr && (bus_addr == OFS_DATA) && !busy;
    assign data_adv = bus_rd && (bus_addr == OFS_DATA);
    assign spi_cs_n = !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            opcode_q <= 8'h00;
            count_q  <= '0;
        end else if (bus_wr) begin
            if (bus_addr == OFS_OPCODE) opcode_q <= bus_wdata;
            if (bus_addr == OFS_COUNT)  count_q  <= count_reg_t'(bus_wdata);
        end
    end

    always_comb begin
        bus_rdata = 8'h00;
        case (bus_addr)
            OFS_OPCODE: bus_rdata = opcode_q;
            OFS_COUNT:  bus_rdata = count_q;
            OFS_CTRL:   bus_rdata[CTRL_GO_BIT] = busy;
            OFS_STATUS: bus_rdata[STAT_BUSY_BIT] = busy;
            OFS_DATA:   bus_rdata = fifo_bus_rdata;
            OFS_PTR:    bus_rdata = 8'(ptr);
            default:    bus_rdata = 8'h00;
        endcase
    end

    spi_cmd_fifo #(.DEPTH(DEPTH)) u_fifo (
        .clk       (clk),
        .rst       (rst),
        .bus_we    (data_we),
        .bus_adv   (data_adv),
        .ptr_clr   (ptr_clr),
        .bus_wdata (bus_wdata),
        .bus_rdata (fifo_bus_rdata),
        .ptr       (ptr),
        .eng_we    (eng_we),
        .eng_waddr (eng_waddr),
        .eng_wdata (eng_wdata),
        .eng_raddr (eng_raddr),
        .eng_rdata (eng_rdata)
    );

    spi_cmd_seq #(.DEPTH(DEPTH), .MAX_TX(MAX_TX)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .go         (go),
        .opcode     (opcode_q),
        .counts     (count_q),
        .byte_done  (byte_done),
        .rx_byte    (rx_byte),
        .fifo_rdata (eng_rdata),
        .fifo_raddr (eng_raddr),
        .fifo_we    (eng_we),
        .fifo_waddr (eng_waddr),
        .fifo_wdata (eng_wdata),
        .load       (load),
        .load_byte  (load_byte),
        .busy       (busy)
    );

    spi_cmd_shift u_shift (
        .clk       (clk),
        .rst       (rst),
        .load      (load),
        .load_byte (load_byte),
        .miso      (spi_miso),
        .byte_done (byte_done),
        .rx_byte   (rx_byte),
        .sclk      (spi_sclk),
        .mosi      (spi_mosi)
    );

    assert_clock_under_select_R10: assert property (@(posedge clk) disable iff (rst)
        spi_sclk |-> !spi_cs_n);

    assert_busy_write_ignored_R11: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && !bus_rd && (bus_addr == OFS_DATA) && busy) |=> $stable(ptr));

endmodule

// File: tb/spi_cmd_engine_tb.sv
module spi_cmd_engine_tb;

    localparam logic [3:0] A_OP = 4'h0, A_CNT = 4'h1, A_CTRL = 4'h2,
                           A_STAT = 4'h3, A_DATA = 4'hC, A_PTR = 4'hD;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] bus_addr = 4'h0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic       spi_sclk, spi_cs_n, spi_mosi, spi_miso;

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    logic [7:0] exp_q[$];

    logic [7:0] slv_seed = 8'h00;
    int sclk_falls = 0;
    int fall_base = 0;
    int cs_falls = 0;
    int seen_falls = 0;
    int last_rise = -1;
    int mon_n = 0;
    logic [7:0] mon_sh = 8'h00;

    spi_cmd_engine u_dut (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .spi_sclk(spi_sclk), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
        .spi_miso(spi_miso)
    );

    always #5 clk = ~clk;
    always @(posedge clk) cyc++;

    function automatic logic [7:0] slv_byte(input logic [7:0] s, input int n);
        return s ^ 8'((n * 29) + 60);
    endfunction

    function automatic logic slv_bit(input logic [7:0] s, input int b);
        logic [7:0] v;
        v = slv_byte(s, b / 8);
        return v[3'(7 - (b % 8))];
    endfunction

    assign spi_miso = slv_bit(slv_seed, sclk_falls - fall_base);

    always @(negedge spi_sclk) sclk_falls++;
    always @(negedge spi_cs_n) begin
        fall_base = sclk_falls;
        cs_falls++;
    end

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, got, exp);
        end
    endtask

    // Scoreboard monitor: rebuilds each MOSI byte and compares with the queue
    always @(posedge spi_sclk) begin
        if (cs_falls != seen_falls) begin
            seen_falls = cs_falls;
            last_rise = -1;
            mon_n = 0;
        end
        chk("R10 clock pulse with select low", {31'd0, spi_cs_n}, 32'd0);
        if (last_rise >= 0) chk("R9 clock period", 32'(cyc - last_rise), 32'd4);
        last_rise = cyc;
        mon_sh = {mon_sh[6:0], spi_mosi};
        mon_n++;
        if (mon_n == 8) begin
            mon_n = 0;
            if (exp_q.size() == 0) begin
                chk("R10 extra serial byte", {24'd0, mon_sh}, 32'h100);
            end else begin
                chk("R2/R9 serial byte", {24'd0, mon_sh}, {24'd0, exp_q.pop_front()});
            end
        end
    end

    task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        #1 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wait_idle(input string req);
        logic [7:0] v;
        bit idle;
        idle = 1'b0;
        for (int n = 0; n < 1000 && !idle; n++) begin
            bus_read(A_CTRL, v);
            idle = !v[0];
        end
        chk(req, {31'd0, idle}, 32'd1);
        repeat (2) @(negedge clk);
        chk({req, " all serial bytes seen"}, 32'(exp_q.size()), 32'd0);
    endtask

    function automatic logic [7:0] pay(input logic [7:0] op, input int i);
        return op ^ 8'((i * 53) + 7);
    endfunction

    task automatic do_xact(input logic [7:0] op, input int txf, input int rxf,
                           input logic [7:0] seed, input string req);
        int txe, rxe;
        logic [7:0] v;
        txe = (txf > 8) ? 8 : txf;
        rxe = (txe != 0) ? rxf : ((rxf == 0) ? 0 : rxf - 1);
        bus_write(A_OP, op);
        bus_write(A_CNT, {4'(rxf), 4'(txf)});
        bus_write(A_CTRL, 8'h10);
        for (int i = 0; i < txe; i++) bus_write(A_DATA, pay(op, i));
        bus_write(A_CTRL, 8'h10);
        slv_seed = seed;
        exp_q.push_back(op);
        for (int i = 0; i < txe; i++) exp_q.push_back(pay(op, i));
        for (int i = 0; i < rxe; i++) exp_q.push_back(8'h00);
        bus_write(A_CTRL, 8'h01);
        bus_read(A_STAT, v);
        chk({req, " R7 busy flag"}, {24'd0, v}, 32'h80);
        wait_idle({req, " R7 completes"});
        bus_write(A_CTRL, 8'h10);
        for (int i = 0; i < txe; i++) begin
            bus_read(A_DATA, v);
            chk({req, " R8 payload kept"}, {24'd0, v}, {24'd0, pay(op, i)});
        end
        for (int i = 0; i < rxe; i++) begin
            bus_read(A_DATA, v);
            chk({req, " R8 received byte"}, {24'd0, v}, {24'd0, slv_byte(seed, 1 + txe + i)});
        end
        bus_read(A_PTR, v);
        chk({req, " R5 pointer after readout"}, {24'd0, v}, 32'((txe + rxe) % 8));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] v;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 cs_n idle high", {31'd0, spi_cs_n}, 32'd1);
        chk("R1 sclk idle low", {31'd0, spi_sclk}, 32'd0);
        bus_read(A_CTRL, v);  chk("R1 control reg", {24'd0, v}, 32'h00);
        bus_read(A_STAT, v);  chk("R1 status reg", {24'd0, v}, 32'h00);
        bus_read(A_PTR, v);   chk("R1 pointer", {24'd0, v}, 32'h00);

        bus_write(A_OP, 8'h9F);
        bus_read(A_OP, v);    chk("R2 opcode readback", {24'd0, v}, 32'h9F);
        bus_write(A_CNT, 8'h52);
        bus_read(A_CNT, v);   chk("R3 count readback", {24'd0, v}, 32'h52);

        for (int i = 0; i < 3; i++) bus_write(A_DATA, 8'(i + 1));
        bus_read(A_PTR, v);   chk("R5 pointer advance", {24'd0, v}, 32'd3);
        for (int i = 0; i < 6; i++) bus_write(A_DATA, 8'(i + 4));
        bus_read(A_PTR, v);   chk("R5 pointer wraps", {24'd0, v}, 32'd1);
        bus_write(A_CTRL, 8'h10);
        bus_read(A_PTR, v);   chk("R6 pointer clear", {24'd0, v}, 32'd0);

        do_xact(8'h9F, 2, 3, 8'h11, "R8 tx2 rx3");
        do_xact(8'h05, 0, 4, 8'h22, "R4 tx0 field4");
        do_xact(8'h03, 0, 1, 8'h33, "R4 tx0 field1");
        do_xact(8'h02, 8, 0, 8'h44, "R3 tx8");
        do_xact(8'h0B, 12, 0, 8'h55, "R3 tx12 clamped");

        // R11: data-port write and repeated go while running
        bus_write(A_CTRL, 8'h10);
        bus_write(A_DATA, 8'hA0);
        bus_write(A_DATA, 8'hA1);
        bus_write(A_OP, 8'h3B);
        bus_write(A_CNT, 8'h22);
        bus_write(A_CTRL, 8'h10);
        slv_seed = 8'h66;
        exp_q.push_back(8'h3B); exp_q.push_back(8'hA0); exp_q.push_back(8'hA1);
        exp_q.push_back(8'h00); exp_q.push_back(8'h00);
        bus_write(A_CTRL, 8'h01);
        bus_write(A_DATA, 8'hEE);
        bus_read(A_PTR, v);   chk("R11 pointer unchanged by busy write", {24'd0, v}, 32'd0);
        bus_write(A_CTRL, 8'h01);
        wait_idle("R11 single run");
        bus_write(A_CTRL, 8'h10);
        bus_read(A_DATA, v);  chk("R11 entry0 intact", {24'd0, v}, 32'hA0);
        bus_read(A_DATA, v);  chk("R11 entry1 intact", {24'd0, v}, 32'hA1);
        bus_read(A_DATA, v);  chk("R11 rx0", {24'd0, v}, {24'd0, slv_byte(8'h66, 3)});
        bus_read(A_DATA, v);  chk("R11 rx1", {24'd0, v}, {24'd0, slv_byte(8'h66, 4)});

        // R6: pointer clear and start in one write
        bus_write(A_CTRL, 8'h10);
        bus_write(A_DATA, 8'hC1);
        bus_write(A_DATA, 8'hC2);
        bus_write(A_OP, 8'h4E);
        bus_write(A_CNT, 8'h12);
        slv_seed = 8'h77;
        exp_q.push_back(8'h4E); exp_q.push_back(8'hC1); exp_q.push_back(8'hC2);
        exp_q.push_back(8'h00);
        bus_write(A_CTRL, 8'h11);
        bus_read(A_PTR, v);   chk("R6 clear with start", {24'd0, v}, 32'd0);
        bus_read(A_STAT, v);  chk("R6 started with clear", {24'd0, v}, 32'h80);
        bus_write(A_DATA, 8'h00);
        bus_write(A_CTRL, 8'h10);
        bus_read(A_PTR, v);   chk("R6 clear while busy", {24'd0, v}, 32'd0);
        wait_idle("R6 run");
        bus_write(A_CTRL, 8'h10);
        bus_read(A_DATA, v);  chk("R6 entry0", {24'd0, v}, 32'hC1);
        bus_read(A_DATA, v);  chk("R6 entry1", {24'd0, v}, 32'hC2);
        bus_read(A_DATA, v);  chk("R6 rx0", {24'd0, v}, {24'd0, slv_byte(8'h77, 3)});
        chk("R10 cs_n high after run", {31'd0, spi_cs_n}, 32'd1);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule